// File: doc/BRIEF.md
# Cascaded Match Priority Resolver

This block is the per-device arbitration logic for a vertical chain of match engines that share one result bus. The array is not modelled here. Each device gets local hit, multiple-hit and full indications from its own array, together with a free-entry address. From these it decides whether it owns the shared result bus. A compare command latches the hit state and matching entry. A write-at-next-free command latches the full state and the free entry. Any other command leaves the latched result untouched. Such a command may therefore be issued while the chain is still settling.

Two active-low ripple chains run from the highest-priority device down to the lowest. The match chain tells lower devices that someone above has already hit. The full chain tells them that every device above is full. A device drives its page-qualified entry address onto the result bus only while the output enable is high. The system raises that enable once the chain has had time to settle. The device flagged as the end of the chain drives an all-ones "no result" word when no device in the chain can answer.

A 32-bit status word can be read over a separate data port. It holds the local flags, active low, which never depend on the chain inputs. It also mirrors whatever is currently on the result bus. The status read is answered either by the device selected directly or by the current bus owner. All pins are plain level-sensitive controls, because no data stream crosses the block.

Top module: `cpr_node`

## Requirements
- R1: After reset, the latched hit, multiple-hit and full flags are clear. Status bits 30, 29 and 28 therefore read 1. The device drives neither the result bus nor the data port unless it is the end-of-chain device.
- R2: `match_out_n` is low exactly when `match_in_n` is low or the latched hit is set.
- R3: `full_out_n` is low exactly when `full_in_n` is low and the latched full flag is set.
- R4: After a compare (op code 1), the device drives `bus_word` = {`cfg_page`, matching entry} when three things hold: `oe` is high, the latched hit is set and `match_in_n` is high.
- R5: With `oe` low, `bus_drive` stays low whatever the latched result is.
- R6: An op code of 3 (non-bus command) changes neither the latched result nor the flags. A later `oe` drives the previous compare's result.
- R7: After a write-at-next-free (op code 2), the device owns the bus when `full_in_n` is low and its own latched full is clear. It then drives {`cfg_page`, free entry}.
- R8: With `cfg_last` set, the device drives the all-ones word under `oe` when no device in the chain can answer. In compare mode, that means `match_in_n` is high and there is no local hit. In free mode, it means `full_in_n` is low and the local full flag is set.
- R9: Status bit 30 is the inverted latched hit, bit 29 the inverted latched multiple-hit and bit 28 the inverted latched full. None of them changes with `match_in_n` or `full_in_n`.
- R10: Status bits 15..0 always equal `res_bus_in`. All other status bits read 0.
- R11: The data port is driven (`dq_drive` high) only while `st_rd` is high. In direct mode (`st_follow` = 0), it is driven when `st_sel` is high. In follow mode (`st_follow` = 1), it is driven only when this device owns the result bus. When not driven, `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page | input | PAGE_W | Device page number, upper part of the result word |
| cfg_last | input | 1 | Marks the lowest-priority device of the chain |
| op | input | 2 | Command: 0 idle, 1 compare, 2 write-at-next-free, 3 other |
| loc_hit | input | 1 | Local array hit |
| loc_multi | input | 1 | Local array multiple hit |
| loc_full | input | 1 | Local array full |
| hit_addr | input | ADDR_W | Highest-priority matching entry in the local array |
| free_addr | input | ADDR_W | First free entry in the local array |
| match_in_n | input | 1 | Active low: a higher device has hit |
| full_in_n | input | 1 | Active low: all higher devices are full |
| match_out_n | output | 1 | Match chain to the next lower device |
| full_out_n | output | 1 | Full chain to the next lower device |
| oe | input | 1 | Result bus output enable |
| bus_drive | output | 1 | This device drives the result bus |
| bus_word | output | PAGE_W+ADDR_W | Word this device places on the result bus |
| res_bus_in | input | PAGE_W+ADDR_W | Resolved value seen on the shared result bus |
| st_rd | input | 1 | Status read strobe |
| st_follow | input | 1 | 1: answered by the bus owner, 0: answered by the selected device |
| st_sel | input | 1 | Direct device select for status reads |
| dq_drive | output | 1 | This device drives the data port |
| dq_out | output | 32 | Status word |

## Verification
Compare results are tried in three chain situations: a local hit with no hit above, a local hit masked by a hit above, and no hit anywhere, both with and without the end-of-chain flag. These cases separate true ownership from masking and from the no-result claim. Write-at-next-free is tried three ways: with this device full, with it free and all devices above full, and with it free but a device above still free. This shows that the full chain picks the first non-full device. A hit with `oe` low, and a non-bus command between a compare and `oe`, show that bus drive is gated by the enable alone and that the latched result survives. Status reads are made in both selection modes, with the chain inputs toggled. They show that the local flags stay independent of the chain and that only one device answers a follow-mode read.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_CMP   = 2'd1,
    OP_NXF   = 2'd2,
    OP_OTHER = 2'd3
  } cpr_op_e;

  localparam int STAT_W      = 32;
  localparam int STAT_HIT_B  = 30;
  localparam int STAT_MULT_B = 29;
  localparam int STAT_FULL_B = 28;
endpackage

// File: rtl/cpr_result_hold.sv
module cpr_result_hold
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cpr_op_e           op,
  input  logic              loc_hit,
  input  logic              loc_multi,
  input  logic              loc_full,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [ADDR_W-1:0] free_addr,
  output logic              hit_q,
  output logic              multi_q,
  output logic              full_q,
  output logic              free_mode_q,
  output logic [ADDR_W-1:0] addr_q
);
  // Only bus-changing commands touch the held result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q       <= 1'b0;
      multi_q     <= 1'b0;
      full_q      <= 1'b0;
      free_mode_q <= 1'b0;
      addr_q      <= '0;
    end else begin
      case (op)
        OP_CMP: begin
          hit_q       <= loc_hit;
          multi_q     <= loc_multi;
          full_q      <= loc_full;
          free_mode_q <= 1'b0;
          addr_q      <= hit_addr;
        end
        OP_NXF: begin
          full_q      <= loc_full;
          free_mode_q <= 1'b1;
          addr_q      <= free_addr;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpr_chain_link.sv
module cpr_chain_link (
  input  logic hit_q,
  input  logic full_q,
  input  logic free_mode_q,
  input  logic cfg_last,
  input  logic match_in_n,
  input  logic full_in_n,
  output logic match_out_n,
  output logic full_out_n,
  output logic own,
  output logic empty_claim
);
  logic up_hit, up_full;

  always_comb begin
    up_hit      = !match_in_n;
    up_full     = !full_in_n;
    match_out_n = !(up_hit || hit_q);
    full_out_n  = !(up_full && full_q);
    if (free_mode_q) begin
      own         = up_full && !full_q;
      empty_claim = cfg_last && up_full && full_q;
    end else begin
      own         = hit_q && !up_hit;
      empty_claim = cfg_last && !up_hit && !hit_q;
    end
  end
endmodule

// File: rtl/cpr_status_port.sv
module cpr_status_port
  import cpr_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              hit_q,
  input  logic              multi_q,
  input  logic              full_q,
  input  logic [BUS_W-1:0]  res_bus_in,
  input  logic              bus_owner,
  input  logic              st_rd,
  input  logic              st_follow,
  input  logic              st_sel,
  output logic              dq_drive,
  output logic [STAT_W-1:0] dq_out
);
  logic [STAT_W-1:0] stat_word;

  always_comb begin
    stat_word              = '0;
    stat_word[BUS_W-1:0]   = res_bus_in;
    stat_word[STAT_HIT_B]  = !hit_q;
    stat_word[STAT_MULT_B] = !multi_q;
    stat_word[STAT_FULL_B] = !full_q;
    dq_drive = st_rd && (st_follow ? bus_owner : st_sel);
    dq_out   = dq_drive ? stat_word : '0;
  end
endmodule

// File: rtl/cpr_node.sv
module cpr_node
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 4,
  localparam int BUS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_last,
  input  logic [1:0]        op,
  input  logic              loc_hit,
  input  logic              loc_multi,
  input  logic              loc_full,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [ADDR_W-1:0] free_addr,
  input  logic              match_in_n,
  input  logic              full_in_n,
  output logic              match_out_n,
  output logic              full_out_n,
  input  logic              oe,
  output logic              bus_drive,
  output logic [BUS_W-1:0]  bus_word,
  input  logic [BUS_W-1:0]  res_bus_in,
  input  logic              st_rd,
  input  logic              st_follow,
  input  logic              st_sel,
  output logic              dq_drive,
  output logic [STAT_W-1:0] dq_out
);
  logic              hit_q, multi_q, full_q, free_mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              own, empty_claim;

  cpr_result_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .op(cpr_op_e'(op)),
    .loc_hit(loc_hit), .loc_multi(loc_multi), .loc_full(loc_full),
    .hit_addr(hit_addr), .free_addr(free_addr),
    .hit_q(hit_q), .multi_q(multi_q), .full_q(full_q),
    .free_mode_q(free_mode_q), .addr_q(addr_q)
  );

  cpr_chain_link u_link (
    .hit_q(hit_q), .full_q(full_q), .free_mode_q(free_mode_q),
    .cfg_last(cfg_last), .match_in_n(match_in_n), .full_in_n(full_in_n),
    .match_out_n(match_out_n), .full_out_n(full_out_n),
    .own(own), .empty_claim(empty_claim)
  );

  always_comb begin
    bus_drive = oe && (own || empty_claim);
    bus_word  = own ? {cfg_page, addr_q} : {BUS_W{1'b1}};
  end

  cpr_status_port #(.BUS_W(BUS_W)) u_stat (
    .hit_q(hit_q), .multi_q(multi_q), .full_q(full_q),
    .res_bus_in(res_bus_in), .bus_owner(own || empty_claim),
    .st_rd(st_rd), .st_follow(st_follow), .st_sel(st_sel),
    .dq_drive(dq_drive), .dq_out(dq_out)
  );
endmodule

// File: rtl/cpr_node_chk.sv
module cpr_node_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     match_in_n,
  input logic                     full_in_n,
  input logic                     match_out_n,
  input logic                     full_out_n,
  input logic                     oe,
  input logic                     bus_drive,
  input logic                     st_rd,
  input logic                     dq_drive,
  input logic [31:0]              dq_out,
  input logic [1:0]               op
);
  a_r5_quiet_without_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !bus_drive);

  a_r2_upstream_hit_ripples: assert property (@(posedge clk) disable iff (!rst_n)
    !match_in_n |-> !match_out_n);

  a_r3_full_needs_upstream: assert property (@(posedge clk) disable iff (!rst_n)
    !full_out_n |-> !full_in_n);

  a_r11_dq_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> st_rd);

  a_r11_dq_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_drive |-> (dq_out == 32'd0));

  a_r6_other_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd3 && st_rd && dq_drive) |=> (!dq_drive || $stable(dq_out[30:28])));
endmodule

bind cpr_node cpr_node_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/cpr_node_tb.sv
module cpr_node_tb;
  localparam int ADDR_W = 12;
  localparam int PAGE_W = 4;
  localparam int BUS_W  = PAGE_W + ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PAGE_W-1:0] cfg_page = 4'h5;
  logic              cfg_last = 1'b0;
  logic [1:0]        op = 2'd0;
  logic              loc_hit = 0, loc_multi = 0, loc_full = 0;
  logic [ADDR_W-1:0] hit_addr = '0, free_addr = '0;
  logic              match_in_n = 1'b1, full_in_n = 1'b1;
  logic              match_out_n, full_out_n;
  logic              oe = 1'b0;
  logic              bus_drive;
  logic [BUS_W-1:0]  bus_word;
  logic [BUS_W-1:0]  res_bus_in = '0;
  logic              st_rd = 0, st_follow = 0, st_sel = 0;
  logic              dq_drive;
  logic [31:0]       dq_out;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  cpr_node #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dut (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic        hit, multi, full;
    logic [11:0] addr;
    logic        mi_n, fi_n, oe, last;
    logic        exp_drv;
    logic [15:0] exp_word;
    logic        exp_mo_n, exp_fo_n;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 1'b0, 1'b0, 12'h123, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h5123, 1'b0, 1'b1}, // R4
    '{2'd1, 1'b1, 1'b0, 1'b0, 12'h0AA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1}, // R2
    '{2'd1, 1'b0, 1'b0, 1'b0, 12'h111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1}, // R4
    '{2'd1, 1'b0, 1'b0, 1'b0, 12'h111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1}, // R8
    '{2'd2, 1'b0, 1'b0, 1'b1, 12'h0F0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0}, // R3
    '{2'd2, 1'b0, 1'b0, 1'b0, 12'h0F0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h50F0, 1'b1, 1'b1}, // R7
    '{2'd2, 1'b0, 1'b0, 1'b0, 12'h0F0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1}, // R7
    '{2'd1, 1'b1, 1'b0, 1'b0, 12'h777, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1}, // R5
    '{2'd2, 1'b0, 1'b0, 1'b1, 12'h333, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0}  // R8
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] o, logic h, logic m, logic f, logic [11:0] a);
    @(negedge clk);
    op = o; loc_hit = h; loc_multi = m; loc_full = f;
    hit_addr = a; free_addr = a;
    @(negedge clk);
    op = 2'd0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    oe = 1'b1; st_rd = 1'b1; st_sel = 1'b1;
    #1;
    check("R1 bus_drive", {31'd0, bus_drive}, 32'd0);
    check("R1 flags", {29'd0, dq_out[30:28]}, 32'd7);
    check("R2 reset match_out_n", {31'd0, match_out_n}, 32'd1);
    oe = 1'b0; st_rd = 1'b0; st_sel = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cfg_last = VECS[i].last; match_in_n = VECS[i].mi_n;
      full_in_n = VECS[i].fi_n; oe = 1'b0;
      do_op(VECS[i].op, VECS[i].hit, VECS[i].multi, VECS[i].full, VECS[i].addr);
      oe = VECS[i].oe;
      #1;
      check($sformatf("R4/R5/R7/R8 drive vec%0d", i), {31'd0, bus_drive}, {31'd0, VECS[i].exp_drv});
      check($sformatf("R2 match_out_n vec%0d", i), {31'd0, match_out_n}, {31'd0, VECS[i].exp_mo_n});
      check($sformatf("R3 full_out_n vec%0d", i), {31'd0, full_out_n}, {31'd0, VECS[i].exp_fo_n});
      if (VECS[i].exp_drv)
        check($sformatf("R4/R7/R8 word vec%0d", i), {16'd0, bus_word}, {16'd0, VECS[i].exp_word});
    end

    // R6: non-bus command between compare and output enable
    oe = 1'b0; cfg_last = 1'b0; match_in_n = 1'b1; full_in_n = 1'b1;
    do_op(2'd1, 1'b1, 1'b1, 1'b0, 12'h234);
    do_op(2'd3, 1'b0, 1'b0, 1'b1, 12'h999);
    oe = 1'b1;
    #1;
    check("R6 drive after other", {31'd0, bus_drive}, 32'd1);
    check("R6 word after other", {16'd0, bus_word}, 32'h5234);

    // R9: local flags via direct status read, independent of chain
    st_rd = 1'b1; st_sel = 1'b1; st_follow = 1'b0; res_bus_in = 16'hBEEF;
    #1;
    check("R11 direct read drive", {31'd0, dq_drive}, 32'd1);
    check("R9 flags", {29'd0, dq_out[30:28]}, 32'd1);
    check("R10 mirror", dq_out & 32'h8FFF_0000, 32'd0);
    check("R10 bus bits", {16'd0, dq_out[15:0]}, 32'hBEEF);
    match_in_n = 1'b0; full_in_n = 1'b0; res_bus_in = 16'h1234;
    #1;
    check("R9 flags vs chain", {29'd0, dq_out[30:28]}, 32'd1);
    check("R10 mirror follows bus", {16'd0, dq_out[15:0]}, 32'h1234);

    // R11: selection modes, exactly one responder
    st_sel = 1'b0;
    #1;
    check("R11 unselected quiet", {31'd0, dq_drive}, 32'd0);
    check("R11 unselected zero", dq_out, 32'd0);
    st_follow = 1'b1; match_in_n = 1'b1;
    #1;
    check("R11 follow owner", {31'd0, dq_drive}, 32'd1);
    match_in_n = 1'b0;
    #1;
    check("R11 follow non-owner", {31'd0, dq_drive}, 32'd0);
    st_rd = 1'b0; match_in_n = 1'b1;
    #1;
    check("R11 no read no drive", {31'd0, dq_drive}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule